// File: doc/BRIEF.md
# TDD Frame Event Scheduler

This block keeps frame time for a time-division-duplex radio link and turns it into the control strobes that the radio front end and the modem need. A single frame counter of `CNT_W` bits wraps every 2^`CNT_W` clock cycles. With the default of 15 bits at an 8.192 MHz clock, this gives a 4 ms frame. Every event is placed relative to the start of the frame. A one-cycle load strobe for the synthesizer marks the frame start. The transmit window and the receive window each take one half of the frame. The base station transmits first and the handset receives first.

Inside each window the matching power enable (modulator or demodulator) is high for the whole half. The antenna/chain select line for that direction asserts after a programmable lead and drops one cycle before the half ends, so the two select lines are never high together. A general RF enable is high whenever the block is awake. A bit-inversion select follows the inversion mode bit while the modulator is enabled.

A processor writes role, inversion mode, sleep request and lead through a small write port. Role, mode and lead only take effect at the next frame start. A sleep request lets the current frame finish, then holds everything quiet until the request is cleared. A fresh frame then starts from zero.

Top module: `tdd_frame_sched`

## Requirements
- R1: While awake, `synth_load_o` is high for exactly one cycle at frame position 0, so pulses are 2^`CNT_W` cycles apart.
- R2: In base role (control bit 0 = 0), `mod_pwr_o` is high at frame positions 0 to HALF-1 and `demod_pwr_o` at positions HALF to 2^`CNT_W`-1, where HALF = 2^(`CNT_W`-1).
- R3: In handset role (control bit 0 = 1), the two halves are swapped: `demod_pwr_o` covers the first half and `mod_pwr_o` the second.
- R4: Let `o` be the offset inside a window. `ant_tx_o` (and `ant_rx_o`) is high when the modulator (demodulator) window is open, `o` >= lead and `o` != HALF-1. The two select lines are never high together.
- R5: The lead is written at address 1 from `wr_data[CNT_W-2:0]` and resets to `LEAD_RST`. A lead of 0 asserts the select line on the first window cycle. A lead of HALF-1 or more keeps the select line low for the whole window.
- R6: Role, inversion mode and lead written during a frame do not change any output before the next frame start. They apply from frame position 0 of the next frame.
- R7: `rf_on_o` is high in every cycle in which the block is awake.
- R8: `bit_inv_o` equals inversion mode (control bit 1) AND `mod_pwr_o`.
- R9: When the sleep bit (control bit 2 at address 0) is set before the last cycle of a frame, that frame completes. From the next cycle `sleep_o` is high and `rf_on_o`, both power enables, both select lines and `synth_load_o` are low.
- R10: A write clearing the sleep bit is followed one cycle later by `sleep_o` still high. In the next cycle `synth_load_o` pulses and a new frame starts at position 0.
- R11: During reset all outputs are low. In the first cycle after reset is released a frame starts with `synth_load_o` high, base role, mode 0 and lead `LEAD_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control (bit0 role, bit1 inversion mode, bit2 sleep), 1: lead |
| wr_data | input | CNT_W-1 | Write data |
| synth_load_o | output | 1 | Synthesizer load strobe at frame start |
| rf_on_o | output | 1 | General RF module enable |
| sleep_o | output | 1 | Sleep request to the rest of the chip |
| mod_pwr_o | output | 1 | Modulator power-up |
| demod_pwr_o | output | 1 | Demodulator power-up |
| ant_tx_o | output | 1 | Antenna/chain select for transmit |
| ant_rx_o | output | 1 | Antenna/chain select for receive |
| bit_inv_o | output | 1 | Bit-inversion select |

## Verification
Every output is registered from the next-state value of the frame counter. A register write therefore shows at the outputs only through a state change at a later edge: a sleep-bit clear leaves `sleep_o` high at the first edge after the write and pulses `synth_load_o` at the second, and role or lead changes appear at the following frame-start edge. The bench model advances one expected output vector per rising edge, using the write inputs as they stood before that edge, and queues it. The monitor compares on the next falling edge, so each expected vector is matched against exactly the edge that produced it. Directed checks around reset, the mid-frame role write and the wake-up sequence are timed by counting falling edges after the write edge.

// File: rtl/tdd_sched_pkg.sv
package tdd_sched_pkg;

  typedef enum logic {
    ROLE_BASE    = 1'b0,
    ROLE_HANDSET = 1'b1
  } role_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_LEAD = 1'b1;

  localparam int CTRL_ROLE_BIT  = 0;
  localparam int CTRL_INV_BIT   = 1;
  localparam int CTRL_SLEEP_BIT = 2;

  localparam int N_WIN  = 2;
  localparam int WIN_TX = 0;
  localparam int WIN_RX = 1;

endpackage

// File: rtl/tdd_cfg_regs.sv
module tdd_cfg_regs
  import tdd_sched_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int LEAD_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-2:0] wr_data,
  input  logic             frame_start,
  output logic             sleep_req,
  output role_e            act_role,
  output logic             act_inv,
  output logic [CNT_W-2:0] act_lead
);
  localparam int LEAD_W = CNT_W - 1;

  role_e             role_q, role_sh;
  logic              inv_q, inv_sh, sleep_q;
  logic [LEAD_W-1:0] lead_q, lead_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      role_q  <= ROLE_BASE;
      inv_q   <= 1'b0;
      sleep_q <= 1'b0;
      lead_q  <= LEAD_W'(LEAD_RST);
      role_sh <= ROLE_BASE;
      inv_sh  <= 1'b0;
      lead_sh <= LEAD_W'(LEAD_RST);
    end else begin
      if (wr_en) begin
        if (wr_addr == ADDR_CTRL) begin
          role_q  <= role_e'(wr_data[CTRL_ROLE_BIT]);
          inv_q   <= wr_data[CTRL_INV_BIT];
          sleep_q <= wr_data[CTRL_SLEEP_BIT];
        end else begin
          lead_q  <= wr_data;
        end
      end
      // frame-start latch: settings seen by the windows change only here
      if (frame_start) begin
        role_sh <= role_q;
        inv_sh  <= inv_q;
        lead_sh <= lead_q;
      end
    end
  end

  always_comb begin
    sleep_req = sleep_q;
    act_role  = frame_start ? role_q : role_sh;
    act_inv   = frame_start ? inv_q  : inv_sh;
    act_lead  = frame_start ? lead_q : lead_sh;
  end

endmodule

// File: rtl/tdd_frame_ctr.sv
module tdd_frame_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             asleep_nx,
  output logic             start_nx
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             asleep_q;

  always_comb begin
    if (asleep_q) begin
      asleep_nx = sleep_req;
      cnt_nx    = '0;
    end else if (cnt_q == LAST && sleep_req) begin
      asleep_nx = 1'b1;
      cnt_nx    = '0;
    end else begin
      asleep_nx = 1'b0;
      cnt_nx    = cnt_q + 1'b1;
    end
    start_nx = !asleep_nx && (cnt_nx == '0);
  end

  // reset parks the counter on the last position so the first edge after
  // release opens a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= LAST;
      asleep_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      asleep_q <= asleep_nx;
    end
  end

  p_hold_zero_r9: assert property (@(posedge clk) disable iff (rst)
    asleep_q |-> (cnt_q == '0));

endmodule

// File: rtl/tdd_window.sv
module tdd_window #(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] pos,
  input  logic             upper_half,
  input  logic [CNT_W-2:0] lead,
  input  logic             live,
  output logic             pwr,
  output logic             sel
);
  logic [CNT_W-1:0] off;
  logic [CNT_W-2:0] low;

  always_comb begin
    off = pos - {upper_half, {(CNT_W-1){1'b0}}};
    low = off[CNT_W-2:0];
    pwr = live && !off[CNT_W-1];
    sel = pwr && (low >= lead) && (low != '1);
  end

endmodule

// File: rtl/tdd_frame_sched.sv
module tdd_frame_sched
  import tdd_sched_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int LEAD_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-2:0] wr_data,
  output logic             synth_load_o,
  output logic             rf_on_o,
  output logic             sleep_o,
  output logic             mod_pwr_o,
  output logic             demod_pwr_o,
  output logic             ant_tx_o,
  output logic             ant_rx_o,
  output logic             bit_inv_o
);
  localparam int LEAD_W = CNT_W - 1;

  logic [CNT_W-1:0]  cnt_nx;
  logic              asleep_nx, start_nx, sleep_req, act_inv;
  role_e             act_role;
  logic [LEAD_W-1:0] act_lead;
  logic [N_WIN-1:0]  upper, pwr_w, sel_w;

  tdd_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .cnt_nx(cnt_nx), .asleep_nx(asleep_nx), .start_nx(start_nx)
  );

  tdd_cfg_regs #(.CNT_W(CNT_W), .LEAD_RST(LEAD_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(start_nx), .sleep_req(sleep_req),
    .act_role(act_role), .act_inv(act_inv), .act_lead(act_lead)
  );

  assign upper[WIN_TX] = (act_role == ROLE_HANDSET);
  assign upper[WIN_RX] = (act_role == ROLE_BASE);

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    tdd_window #(.CNT_W(CNT_W)) u_win (
      .pos(cnt_nx), .upper_half(upper[w]), .lead(act_lead),
      .live(!asleep_nx), .pwr(pwr_w[w]), .sel(sel_w[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synth_load_o <= 1'b0;
      rf_on_o      <= 1'b0;
      sleep_o      <= 1'b0;
      mod_pwr_o    <= 1'b0;
      demod_pwr_o  <= 1'b0;
      ant_tx_o     <= 1'b0;
      ant_rx_o     <= 1'b0;
      bit_inv_o    <= 1'b0;
    end else begin
      synth_load_o <= start_nx;
      rf_on_o      <= !asleep_nx;
      sleep_o      <= asleep_nx;
      mod_pwr_o    <= pwr_w[WIN_TX];
      demod_pwr_o  <= pwr_w[WIN_RX];
      ant_tx_o     <= sel_w[WIN_TX];
      ant_rx_o     <= sel_w[WIN_RX];
      bit_inv_o    <= act_inv && pwr_w[WIN_TX];
    end
  end

  p_sel_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(ant_tx_o && ant_rx_o));

  p_tx_sel_in_win_r4: assert property (@(posedge clk) disable iff (rst)
    ant_tx_o |-> mod_pwr_o);

  p_rx_sel_in_win_r4: assert property (@(posedge clk) disable iff (rst)
    ant_rx_o |-> demod_pwr_o);

  p_pwr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mod_pwr_o && demod_pwr_o));

  p_load_single_r1: assert property (@(posedge clk) disable iff (rst)
    synth_load_o |=> !synth_load_o);

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> !(rf_on_o || mod_pwr_o || demod_pwr_o || synth_load_o));

  p_wake_load_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_o) |-> synth_load_o);

  p_inv_in_tx_r8: assert property (@(posedge clk) disable iff (rst)
    bit_inv_o |-> mod_pwr_o);

endmodule

// File: tb/tdd_frame_sched_test.sv
module tdd_frame_sched_test;
  localparam int CW    = 6;
  localparam int FRAME = 1 << CW;
  localparam int HALF  = FRAME / 2;
  localparam int LW    = CW - 1;
  localparam int LEAD0 = 4;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_addr = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic synth_load_o, rf_on_o, sleep_o, mod_pwr_o, demod_pwr_o;
  logic ant_tx_o, ant_rx_o, bit_inv_o;

  always #2 clk = ~clk;

  tdd_frame_sched #(.CNT_W(CW), .LEAD_RST(LEAD0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .synth_load_o(synth_load_o), .rf_on_o(rf_on_o), .sleep_o(sleep_o),
    .mod_pwr_o(mod_pwr_o), .demod_pwr_o(demod_pwr_o), .ant_tx_o(ant_tx_o),
    .ant_rx_o(ant_rx_o), .bit_inv_o(bit_inv_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic load, rfon, slp, modp, demodp, atx, arx, inv;
    logic handset, lead_big, woke, first;
  } exp_t;

  exp_t q[$];

  logic          m_role, m_mode, m_sleep, a_role, a_mode;
  logic [LW-1:0] m_lead, a_lead;
  int            m_k;
  bit            m_asleep, m_inrst;

  // expected-output model: one vector per rising edge, from the requirements
  always @(posedge clk) begin : model
    exp_t e;
    int nk, ts, rs, off;
    bit na;
    e = '0;
    if (rst) begin
      m_role = 0; m_mode = 0; m_sleep = 0; m_lead = LW'(LEAD0);
      a_role = 0; a_mode = 0; a_lead = LW'(LEAD0);
      m_k = FRAME - 1; m_asleep = 0; m_inrst = 1;
    end else begin
      if (m_asleep) begin
        na = m_sleep; nk = 0;
      end else if (m_k == FRAME - 1 && m_sleep) begin
        na = 1; nk = 0;
      end else begin
        na = 0; nk = (m_k + 1) % FRAME;
      end
      if (!na && nk == 0) begin
        a_role = m_role; a_mode = m_mode; a_lead = m_lead;
      end
      e.woke = m_asleep && !na;
      e.first = m_inrst;
      e.handset = a_role;
      e.lead_big = (int'(a_lead) >= HALF - 1);
      if (na) e.slp = 1;
      else begin
        e.rfon = 1;
        e.load = (nk == 0);
        ts = a_role ? HALF : 0;
        rs = a_role ? 0 : HALF;
        if (nk >= ts && nk < ts + HALF) begin
          off = nk - ts; e.modp = 1;
          e.atx = (off >= int'(a_lead)) && (off != HALF - 1);
        end
        if (nk >= rs && nk < rs + HALF) begin
          off = nk - rs; e.demodp = 1;
          e.arx = (off >= int'(a_lead)) && (off != HALF - 1);
        end
        e.inv = a_mode && e.modp;
      end
      m_k = nk; m_asleep = na; m_inrst = 0;
      if (wr_en) begin
        if (wr_addr == 1'b0) begin
          m_role = wr_data[0]; m_mode = wr_data[1]; m_sleep = wr_data[2];
        end else m_lead = wr_data;
      end
    end
    q.push_back(e);
  end

  // monitor: compares on the falling edge after the producing rising edge
  always @(negedge clk) begin : monitor
    exp_t e;
    string tl, tw, ts;
    if (q.size() > 0) begin
      e = q.pop_front();
      tl = e.first ? "R11" : (e.woke ? "R10" : "R1");
      tw = e.handset ? "R3" : "R2";
      ts = e.lead_big ? "R5" : "R4";
      chk(synth_load_o == e.load, tl, "synth_load", synth_load_o, e.load);
      chk(rf_on_o == e.rfon, "R7", "rf_on", rf_on_o, e.rfon);
      chk(sleep_o == e.slp, "R9", "sleep", sleep_o, e.slp);
      chk(mod_pwr_o == e.modp, tw, "mod_pwr", mod_pwr_o, e.modp);
      chk(demod_pwr_o == e.demodp, tw, "demod_pwr", demod_pwr_o, e.demodp);
      chk(ant_tx_o == e.atx, ts, "ant_tx", ant_tx_o, e.atx);
      chk(ant_rx_o == e.arx, ts, "ant_rx", ant_rx_o, e.arx);
      chk(bit_inv_o == e.inv, "R8", "bit_inv", bit_inv_o, e.inv);
      chk(!(ant_tx_o && ant_rx_o), "R4", "select overlap", int'(ant_tx_o && ant_rx_o), 0);
    end
  end

  task automatic wr(input logic a, input logic [LW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_k(input int k);
    @(negedge clk);
    while (!(m_k == k && !m_asleep)) @(negedge clk);
  endtask

  task automatic all_low(input string what);
    logic [7:0] v;
    v = {synth_load_o, rf_on_o, sleep_o, mod_pwr_o, demod_pwr_o,
         ant_tx_o, ant_rx_o, bit_inv_o};
    chk(v == 8'h00, "R11", what, v, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    all_low("outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(synth_load_o == 1'b1, "R11", "first frame load", synth_load_o, 1);
    repeat (2 * FRAME) @(negedge clk);

    wr(1'b1, LW'(0));                       // R5 lead zero
    repeat (2 * FRAME) @(negedge clk);

    wait_k(10);                             // R6 mid-frame role/mode change
    wr(1'b0, LW'(3));
    chk(mod_pwr_o == 1'b1, "R6", "mod_pwr right after write", mod_pwr_o, 1);
    wait_k(0);
    chk(mod_pwr_o == 1'b0 && demod_pwr_o == 1'b1, "R6", "handset at next frame",
        {mod_pwr_o, demod_pwr_o}, 1);
    repeat (2 * FRAME) @(negedge clk);

    wr(1'b1, LW'(HALF - 1));                // R5 lead too large
    repeat (2 * FRAME) @(negedge clk);
    wr(1'b1, LW'(HALF - 2));
    repeat (2 * FRAME) @(negedge clk);
    wr(1'b1, LW'(7));

    wait_k(20);                             // R9 sleep mid-frame
    wr(1'b0, LW'(7));
    wait_k(FRAME - 1);
    @(negedge clk);
    chk(sleep_o == 1'b1 && rf_on_o == 1'b0, "R9", "asleep after frame end",
        {sleep_o, rf_on_o}, 2);
    repeat (100) @(negedge clk);
    wr(1'b0, LW'(3));                       // R10 wake
    chk(sleep_o == 1'b1, "R10", "sleep one cycle after clear", sleep_o, 1);
    @(negedge clk);
    chk(synth_load_o == 1'b1 && sleep_o == 1'b0, "R10", "load on wake",
        {synth_load_o, sleep_o}, 2);
    repeat (FRAME) @(negedge clk);

    wr(1'b0, LW'(0));                       // base role, then sleep set on last cycle
    wait_k(FRAME - 1);
    wr(1'b0, LW'(4));
    repeat (FRAME + 20) @(negedge clk);
    chk(sleep_o == 1'b1, "R9", "sleep after following frame", sleep_o, 1);
    wr(1'b0, LW'(0));
    repeat (2 * FRAME) @(negedge clk);

    wait_k(FRAME - 2);                      // sleep set one cycle before frame end
    wr(1'b0, LW'(4));
    @(negedge clk);
    chk(sleep_o == 1'b1, "R9", "sleep at frame boundary", sleep_o, 1);
    wr(1'b0, LW'(0));
    repeat (FRAME) @(negedge clk);

    rst = 1'b1;                             // R11 reset during operation
    repeat (3) @(negedge clk);
    all_low("outputs in second reset");
    rst = 1'b0;
    @(negedge clk);
    chk(synth_load_o == 1'b1 && mod_pwr_o == 1'b1, "R11", "restart in base role",
        {synth_load_o, mod_pwr_o}, 3);
    repeat (FRAME) @(negedge clk);

    summary();
    $finish;
  end

endmodule